// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing side of a tile-based video engine. It gives the CPU eight byte-wide register slots. An external address decoder asserts the active-low select for the whole $2000 to $3FFF CPU range. The low three address bits pick the slot, so the eight slots repeat every 8 bytes across that range. The bidirectional data bus is split into a write-data input, a read-data output and an output enable for the pad. Rendering, memory timing and video output live elsewhere. A single frame-start pulse stands in for the frame timing, and one input carries the byte fetched from video memory.

The block's main feature is its reset behaviour. Reset clears the control byte, the mask byte, the scroll/address staging word, the fine horizontal scroll, the two-write toggle and the video-memory read buffer. These items then stay at zero, and writes to them are dropped, until the first frame-start pulse after reset is released. Slots outside this group take writes at once.

A control bit reverses a 4-bit colour-index port. As an output, it drives the renderer's pixel index. As an input, its value selects the backdrop palette entry. The interrupt line is open drain: an enable with a constant-low data value.

Top module: `vid_regport`

## Requirements
- R1: An access happens on a rising clock edge while `cs_n` is 0. `rw`=1 is a read and `rw`=0 is a write, and `reg_sel` picks slot 0..7. `cpu_rd_oe` is 1 only while a read is presented. When `cs_n` is 1, nothing changes.
- R2: Reset clears control (slot 0), mask (slot 1), object address (slot 3), object data (slot 4), the staging word, fine scroll, toggle, read buffer, frame flag and frame parity. Reset also arms the hold.
- R3: While the hold is armed, writes to slots 0, 1, 5 and 6 are dropped and the read buffer stays 0. The hold is shown in status bit 5.
- R4: The hold ends at the first `frame_start` after reset release. A held-slot write in the same cycle as that pulse is dropped, and held-slot writes in later cycles take effect.
- R5: Slots 3 and 4 take writes during the hold. A write to slot 4 stores the byte and adds 1 to slot 3. Both slots read back.
- R6: Slot 5 writes alternate. When the toggle is 0, d[7:3] goes to staging bits [4:0] and d[2:0] goes to fine scroll. When the toggle is 1, d[2:0] goes to staging bits [14:12] and d[7:3] goes to staging bits [9:5]. The toggle flips on each write to slot 5 or slot 6.
- R7: Slot 6 writes alternate. When the toggle is 0, staging [13:8] takes d[5:0] and staging bit 14 is cleared. When the toggle is 1, staging [7:0] takes d, and the staging word is copied to the video address (`vram_addr` = bits [13:0]). Slot 5 reads back staging [7:0]. Slot 6 reads back {toggle, staging [14:8]}.
- R8: Slot 2 reads {frame flag, frame parity, hold, 0, 0, fine scroll[2:0]}. A read of slot 2 clears the frame flag and the toggle. `frame_start` sets the flag, and it wins over a clear in the same cycle.
- R9: A read of slot 7 returns the read buffer, then loads the buffer from `vram_rd_data`. Any access to slot 7 advances the video address by 1, or by 32 when control bit 2 is set.
- R10: Control bit 6 set: `ext_oe`=1, `ext_out`=`pix_index` and `backdrop_idx`=0. Control bit 6 clear: `ext_oe`=0 and `backdrop_idx`=`ext_in`.
- R11: `irq_oe` is 1 exactly when control bit 7 and the frame flag are both 1. `irq_out` is always 0.
- R12: `frame_odd` is 0 after reset and inverts on each `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame-start pulse |
| cs_n | input | 1 | Active-low register select |
| rw | input | 1 | 1 read, 0 write |
| reg_sel | input | 3 | Slot index |
| cpu_wdata | input | 8 | Write data from CPU |
| cpu_rdata | output | 8 | Read data to CPU |
| cpu_rd_oe | output | 1 | Read data pad enable |
| vram_rd_data | input | 8 | Byte fetched at the current video address |
| vram_addr | output | 14 | Current video address |
| pix_index | input | 4 | Renderer palette index |
| ext_in | input | 4 | Colour-index port input value |
| ext_out | output | 4 | Colour-index port output value |
| ext_oe | output | 1 | Colour-index port drive enable |
| backdrop_idx | output | 4 | Backdrop palette entry selection |
| irq_oe | output | 1 | Interrupt pull-down enable |
| irq_out | output | 1 | Interrupt data, constant 0 |
| frame_odd | output | 1 | Frame parity |

## Verification
Two pairs of functions can meet in one cycle. In the first, the `frame_start` pulse that ends the reset hold arrives while the CPU writes the control slot. The bench drives both in one cycle and expects the control byte to read back zero, and the slave port and interrupt enable to stay off. A write one cycle later must take. In the second, a status read falls in the same cycle as a frame pulse. The read must return the old, cleared flag, and afterwards the flag and the interrupt enable must be set. This is judged by the next status read and by `irq_oe`.

// File: rtl/vid_regport_pkg.sv
package vid_regport_pkg;

  localparam int DW = 8;
  localparam int TW = 15;

  typedef enum logic [2:0] {
    SLOT_CTRL   = 3'd0,
    SLOT_MASK   = 3'd1,
    SLOT_STAT   = 3'd2,
    SLOT_OADDR  = 3'd3,
    SLOT_ODATA  = 3'd4,
    SLOT_SCROLL = 3'd5,
    SLOT_ADDR   = 3'd6,
    SLOT_DATA   = 3'd7
  } slot_e;

  // first scroll write: coarse horizontal part of the staging word
  function automatic logic [TW-1:0] scroll_lo(logic [TW-1:0] t, logic [DW-1:0] d);
    return {t[TW-1:5], d[7:3]};
  endfunction

  // second scroll write: fine and coarse vertical parts
  function automatic logic [TW-1:0] scroll_hi(logic [TW-1:0] t, logic [DW-1:0] d);
    return {d[2:0], t[11:10], d[7:3], t[4:0]};
  endfunction

  // first address write: upper six bits, top bit cleared
  function automatic logic [TW-1:0] addr_hi(logic [TW-1:0] t, logic [DW-1:0] d);
    return {1'b0, d[5:0], t[7:0]};
  endfunction

  // second address write: low byte
  function automatic logic [TW-1:0] addr_lo(logic [TW-1:0] t, logic [DW-1:0] d);
    return {t[TW-1:8], d};
  endfunction

  function automatic logic [TW-1:0] vaddr_step(logic [TW-1:0] v, logic big);
    return v + (big ? TW'(32) : TW'(1));
  endfunction

endpackage

// File: rtl/vid_regport_decode.sv
module vid_regport_decode #(
  parameter int SEL_W = 3,
  localparam int NSLOT = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic [SEL_W-1:0] sel,
  output logic [NSLOT-1:0] wr_stb,
  output logic [NSLOT-1:0] rd_stb,
  output logic             rd_oe
);

  logic acc_wr, acc_rd;
  assign acc_wr = !cs_n && !rw;
  assign acc_rd = !cs_n && rw;
  assign rd_oe  = acc_rd;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign wr_stb[i] = acc_wr && (sel == SEL_W'(i));
    assign rd_stb[i] = acc_rd && (sel == SEL_W'(i));
  end

  // R1
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_stb, rd_stb}) <= 1);

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (wr_stb == '0 && rd_stb == '0 && !rd_oe));

endmodule

// File: rtl/vid_regport_frame.sv
module vid_regport_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic stat_rd,
  output logic hold,
  output logic frame_odd,
  output logic frame_flag
);

  logic hold_q, odd_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      odd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (frame_start) begin
        hold_q <= 1'b0;
        odd_q  <= ~odd_q;
        flag_q <= 1'b1;
      end else if (stat_rd) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign hold       = hold_q;
  assign frame_odd  = odd_q;
  assign frame_flag = flag_q;

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && frame_start) |=> !hold_q);

  // R4
  hold_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> !hold_q);

  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_start) |=> !flag_q);

  // R12
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (odd_q != $past(odd_q)));

endmodule

// File: rtl/vid_regport_scroll.sv
module vid_regport_scroll
  import vid_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          wr_scroll,
  input  logic          wr_addr,
  input  logic          stat_rd,
  input  logic          data_acc,
  input  logic          inc32,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] stage,
  output logic [2:0]    fine_x,
  output logic          toggle,
  output logic [TW-1:0] vaddr
);

  logic [TW-1:0] t_q, v_q;
  logic [2:0]    fx_q;
  logic          w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      v_q  <= '0;
      fx_q <= '0;
      w_q  <= 1'b0;
    end else begin
      if (hold) begin
        t_q  <= '0;
        fx_q <= '0;
        w_q  <= 1'b0;
      end else if (stat_rd) begin
        w_q <= 1'b0;
      end else if (wr_scroll) begin
        if (!w_q) begin
          t_q  <= scroll_lo(t_q, wdata);
          fx_q <= wdata[2:0];
        end else begin
          t_q <= scroll_hi(t_q, wdata);
        end
        w_q <= ~w_q;
      end else if (wr_addr) begin
        if (!w_q) begin
          t_q <= addr_hi(t_q, wdata);
        end else begin
          t_q <= addr_lo(t_q, wdata);
          v_q <= addr_lo(t_q, wdata);
        end
        w_q <= ~w_q;
      end
      if (data_acc) v_q <= vaddr_step(v_q, inc32);
    end
  end

  assign stage  = t_q;
  assign fine_x = fx_q;
  assign toggle = w_q;
  assign vaddr  = v_q;

  // R3
  scroll_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (t_q == '0 && fx_q == '0 && !w_q));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (wr_scroll || wr_addr)) |=> (w_q != $past(w_q)));

  // R9
  vaddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !inc32) |=> (v_q == $past(v_q) + TW'(1)));

endmodule

// File: rtl/vid_regport_ext.sv
module vid_regport_ext #(
  parameter int EXT_W = 4
) (
  input  logic             slave,
  input  logic [EXT_W-1:0] pix_index,
  input  logic [EXT_W-1:0] ext_in,
  output logic [EXT_W-1:0] ext_out,
  output logic             ext_oe,
  output logic [EXT_W-1:0] backdrop_idx
);

  assign ext_oe       = slave;
  assign ext_out      = slave ? pix_index : '0;
  assign backdrop_idx = slave ? '0 : ext_in;

endmodule

// File: rtl/vid_regport.sv
module vid_regport
  import vid_regport_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int EXT_W      = 4,
  parameter int VADDR_W    = 14,
  parameter int INC_BIT    = 2,
  parameter int SLAVE_BIT  = 6,
  parameter int IRQ_EN_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               cs_n,
  input  logic               rw,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rd_oe,
  input  logic [DW-1:0]      vram_rd_data,
  output logic [VADDR_W-1:0] vram_addr,
  input  logic [EXT_W-1:0]   pix_index,
  input  logic [EXT_W-1:0]   ext_in,
  output logic [EXT_W-1:0]   ext_out,
  output logic               ext_oe,
  output logic [EXT_W-1:0]   backdrop_idx,
  output logic               irq_oe,
  output logic               irq_out,
  output logic               frame_odd
);

  localparam int NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0] wr_stb, rd_stb;
  logic             hold, frame_flag, toggle;
  logic [TW-1:0]    stage, vaddr;
  logic [2:0]       fine_x;
  logic [DW-1:0]    ctrl_q, mask_q, oaddr_q, odata_q, rdbuf_q;
  logic             stat_rd, data_acc;

  vid_regport_decode #(.SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sel(reg_sel),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_oe(cpu_rd_oe)
  );

  assign stat_rd  = rd_stb[SLOT_STAT];
  assign data_acc = rd_stb[SLOT_DATA] | wr_stb[SLOT_DATA];

  vid_regport_frame u_frame (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .stat_rd(stat_rd),
    .hold(hold), .frame_odd(frame_odd), .frame_flag(frame_flag)
  );

  vid_regport_scroll u_scroll (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .wr_scroll(wr_stb[SLOT_SCROLL]), .wr_addr(wr_stb[SLOT_ADDR]),
    .stat_rd(stat_rd), .data_acc(data_acc), .inc32(ctrl_q[INC_BIT]),
    .wdata(cpu_wdata), .stage(stage), .fine_x(fine_x), .toggle(toggle),
    .vaddr(vaddr)
  );

  vid_regport_ext #(.EXT_W(EXT_W)) u_ext (
    .slave(ctrl_q[SLAVE_BIT]), .pix_index(pix_index), .ext_in(ext_in),
    .ext_out(ext_out), .ext_oe(ext_oe), .backdrop_idx(backdrop_idx)
  );

  // held group: control, mask, read buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      rdbuf_q <= '0;
    end else if (hold) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      rdbuf_q <= '0;
    end else begin
      if (wr_stb[SLOT_CTRL]) ctrl_q <= cpu_wdata;
      if (wr_stb[SLOT_MASK]) mask_q <= cpu_wdata;
      if (rd_stb[SLOT_DATA]) rdbuf_q <= vram_rd_data;
    end
  end

  // free group: object address and data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oaddr_q <= '0;
      odata_q <= '0;
    end else if (wr_stb[SLOT_OADDR]) begin
      oaddr_q <= cpu_wdata;
    end else if (wr_stb[SLOT_ODATA]) begin
      odata_q <= cpu_wdata;
      oaddr_q <= oaddr_q + DW'(1);
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd_oe) begin
      unique case (slot_e'(reg_sel))
        SLOT_CTRL:   cpu_rdata = ctrl_q;
        SLOT_MASK:   cpu_rdata = mask_q;
        SLOT_STAT:   cpu_rdata = {frame_flag, frame_odd, hold, 2'b00, fine_x};
        SLOT_OADDR:  cpu_rdata = oaddr_q;
        SLOT_ODATA:  cpu_rdata = odata_q;
        SLOT_SCROLL: cpu_rdata = stage[7:0];
        SLOT_ADDR:   cpu_rdata = {toggle, stage[TW-1:8]};
        SLOT_DATA:   cpu_rdata = rdbuf_q;
        default:     cpu_rdata = '0;
      endcase
    end
  end

  assign vram_addr = vaddr[VADDR_W-1:0];
  assign irq_oe    = ctrl_q[IRQ_EN_BIT] & frame_flag;
  assign irq_out   = 1'b0;

  // R3
  held_regs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ctrl_q == '0 && mask_q == '0 && rdbuf_q == '0));

  // R4
  held_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && wr_stb[SLOT_CTRL]) |=> (ctrl_q == '0));

  // R5
  oaddr_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[SLOT_ODATA] |=> (oaddr_q == $past(oaddr_q) + DW'(1)));

  // R11
  irq_quiet_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (!hold && !irq_out));

  // R10
  ext_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !ext_oe);

endmodule

// File: tb/tb_vid_regport.sv
module tb_vid_regport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       cs_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] reg_sel = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_rd_oe;
  logic [7:0] vram_rd_data = '0;
  logic [13:0] vram_addr;
  logic [3:0] pix_index = '0;
  logic [3:0] ext_in = '0;
  logic [3:0] ext_out;
  logic       ext_oe;
  logic [3:0] backdrop_idx;
  logic       irq_oe;
  logic       irq_out;
  logic       frame_odd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vid_regport dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cs_n(cs_n), .rw(rw),
    .reg_sel(reg_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rd_oe(cpu_rd_oe), .vram_rd_data(vram_rd_data), .vram_addr(vram_addr),
    .pix_index(pix_index), .ext_in(ext_in), .ext_out(ext_out), .ext_oe(ext_oe),
    .backdrop_idx(backdrop_idx), .irq_oe(irq_oe), .irq_out(irq_out),
    .frame_odd(frame_odd)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input bit fs = 1'b0);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; reg_sel = s; cpu_wdata = d; frame_start = fs;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1; frame_start = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] q, input bit fs = 1'b0);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; reg_sel = s; frame_start = fs;
    #1;
    q = cpu_rdata;
    @(negedge clk);
    cs_n = 1'b1; frame_start = 1'b0;
    #1;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    do_reset();
    chk("R2", "frame_odd", 16'(frame_odd), 16'h0);
    chk("R10", "ext_oe after reset", 16'(ext_oe), 16'h0);
    chk("R11", "irq_oe after reset", 16'(irq_oe), 16'h0);
    chk("R11", "irq_out", 16'(irq_out), 16'h0);
    chk("R1", "rd_oe idle", 16'(cpu_rd_oe), 16'h0);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; reg_sel = 3'd2;
    #1;
    chk("R1", "rd_oe during read", 16'(cpu_rd_oe), 16'h1);
    chk("R3", "status shows hold", 16'(cpu_rdata), 16'h20);
    @(negedge clk);
    cs_n = 1'b1;
    rd(3'd0, q);
    chk("R2", "ctrl after reset", 16'(q), 16'h0);
  endtask

  task automatic t_hold();
    logic [7:0] q;
    wr(3'd0, 8'hC4);
    rd(3'd0, q);
    chk("R3", "ctrl write in hold", 16'(q), 16'h0);
    wr(3'd1, 8'h1E);
    rd(3'd1, q);
    chk("R3", "mask write in hold", 16'(q), 16'h0);
    wr(3'd5, 8'hFF);
    rd(3'd5, q);
    chk("R3", "scroll write in hold", 16'(q), 16'h0);
    rd(3'd6, q);
    chk("R3", "toggle in hold", 16'(q), 16'h0);
    vram_rd_data = 8'h5A;
    rd(3'd7, q);
    rd(3'd7, q);
    chk("R3", "read buffer in hold", 16'(q), 16'h0);
    wr(3'd3, 8'h10);
    wr(3'd4, 8'hAB);
    rd(3'd3, q);
    chk("R5", "object address bump", 16'(q), 16'h11);
    rd(3'd4, q);
    chk("R5", "object data", 16'(q), 16'hAB);
  endtask

  task automatic t_release();
    logic [7:0] q;
    // write to control in the same cycle as the releasing frame pulse
    wr(3'd0, 8'h40, 1'b1);
    rd(3'd0, q);
    chk("R4", "ctrl write on release pulse", 16'(q), 16'h0);
    chk("R10", "port still input", 16'(ext_oe), 16'h0);
    chk("R12", "parity after pulse", 16'(frame_odd), 16'h1);
    rd(3'd2, q);
    chk("R8", "status after release", 16'(q), 16'hC0);
    wr(3'd0, 8'h40);
    rd(3'd0, q);
    chk("R4", "ctrl write after release", 16'(q), 16'h40);
  endtask

  task automatic t_scroll();
    logic [7:0] q;
    wr(3'd5, 8'h7D);
    rd(3'd5, q);
    chk("R6", "scroll first low byte", 16'(q), 16'h0F);
    rd(3'd6, q);
    chk("R7", "toggle set", 16'(q), 16'h80);
    wr(3'd5, 8'h5E);
    rd(3'd5, q);
    chk("R6", "scroll second low byte", 16'(q), 16'h6F);
    rd(3'd6, q);
    chk("R6", "scroll second high", 16'(q), 16'h61);
    rd(3'd2, q);
    chk("R8", "status fine scroll", 16'(q), 16'h45);
  endtask

  task automatic t_addr();
    logic [7:0] q;
    wr(3'd6, 8'hE3);
    rd(3'd6, q);
    chk("R7", "address first write", 16'(q), 16'hA3);
    wr(3'd6, 8'h40);
    chk("R7", "video address copy", 16'(vram_addr), 16'h2340);
    vram_rd_data = 8'h5A;
    rd(3'd7, q);
    chk("R9", "first data read old buffer", 16'(q), 16'h00);
    chk("R9", "address +1", 16'(vram_addr), 16'h2341);
    rd(3'd7, q);
    chk("R9", "second data read", 16'(q), 16'h5A);
    wr(3'd0, 8'h44);
    wr(3'd7, 8'h00);
    chk("R9", "address +32", 16'(vram_addr), 16'h2362);
  endtask

  task automatic t_ext();
    pix_index = 4'h9;
    ext_in = 4'hB;
    #1;
    chk("R10", "slave drive enable", 16'(ext_oe), 16'h1);
    chk("R10", "slave drives pixel", 16'(ext_out), 16'h9);
    chk("R10", "slave backdrop", 16'(backdrop_idx), 16'h0);
    wr(3'd0, 8'h00);
    chk("R10", "input mode enable", 16'(ext_oe), 16'h0);
    chk("R10", "input backdrop", 16'(backdrop_idx), 16'hB);
    ext_in = 4'h0;
    #1;
    chk("R10", "grounded backdrop", 16'(backdrop_idx), 16'h0);
  endtask

  task automatic t_irq();
    logic [7:0] q;
    wr(3'd0, 8'h80);
    chk("R11", "irq idle", 16'(irq_oe), 16'h0);
    frame_pulse();
    chk("R11", "irq on frame", 16'(irq_oe), 16'h1);
    chk("R11", "irq data low", 16'(irq_out), 16'h0);
    rd(3'd2, q);
    chk("R8", "status flag and parity", 16'(q), 16'h85);
    chk("R11", "irq after status read", 16'(irq_oe), 16'h0);
  endtask

  task automatic t_same();
    logic [7:0] q;
    rd(3'd2, q, 1'b1);
    chk("R8", "status read with pulse", 16'(q), 16'h05);
    chk("R8", "flag survives clear", 16'(irq_oe), 16'h1);
    rd(3'd2, q);
    chk("R8", "status next read", 16'(q), 16'hC5);
    chk("R12", "parity", 16'(frame_odd), 16'h1);
  endtask

  task automatic t_rehold();
    logic [7:0] q;
    do_reset();
    rd(3'd2, q);
    chk("R2", "status after second reset", 16'(q), 16'h20);
    rd(3'd3, q);
    chk("R2", "object address reset", 16'(q), 16'h00);
    chk("R2", "parity reset", 16'(frame_odd), 16'h0);
    frame_pulse();
    wr(3'd0, 8'h80);
    rd(3'd0, q);
    chk("R4", "ctrl after pulse", 16'(q), 16'h80);
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; reg_sel = 3'd0; cpu_wdata = 8'hFF;
    @(negedge clk);
    rw = 1'b1;
    rd(3'd0, q);
    chk("R1", "deselected write ignored", 16'(q), 16'h80);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_release();
    t_scroll();
    t_addr();
    t_ext();
    t_irq();
    t_same();
    t_rehold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule